// File: doc/BRIEF.md
# Self-Timed Synchronous SRAM Controller

This block is a synchronous memory of 64 words by 4 bits together with the sequencer that runs each access as a chain of short phases, so that it saves power. A clock edge with chip enable high, seen while the block is idle, latches the address, the write data and the write flag. The sequencer then releases bitline precharge, turns on the decoders and the selected word line and, for a read, turns on the sense stage. A dummy reference cell sits on the same word-line timing and reports when an access has had enough time. That completion signal turns off the word line, the decoders and the sense stage at once and starts precharge again. The decoders and the word line do not stay on for a full access window.

The cell array is a behavioural register model. The time the dummy path needs is a parameter, counted in clock ticks. The read data bus has a tristate output stage controlled by the output enable. Four debug outputs show the decode, word-line, sense and precharge phases.

Top module: `selftimed_sram`

## Requirements
- R1: After reset, precharge is on, decode, word line and sense are off, and q reads 0 while oe is high.
- R2: A clock edge with ce high while idle starts an access. In the cycle after that edge, decode is on, precharge is off and the word line is still off.
- R3: The word line turns on one cycle after decode. It stays on for exactly DUMMY_TICKS cycles, and then the word line and decode turn off together.
- R4: In a read, sense is on from the second word-line cycle to the last word-line cycle and turns off with the word line. Sense never turns on in a write.
- R5: In the cycle after the word line drops (the completion), precharge is on. The block is then idle and accepts a new access DUMMY_TICKS+3 cycles after the previous capture edge.
- R6: During a read, q keeps its previous value up to and including the last word-line cycle. It shows the addressed word from the completion cycle (DUMMY_TICKS+1 cycles after the capture edge) onward.
- R7: A write stores d into the addressed word. A later read of that address returns it, and the other words keep their contents.
- R8: With oe low, q is high impedance on all bits. Toggling oe does not change the read data that q shows once oe is high again.
- R9: With ce low at an idle edge, no phase output changes, memory is unchanged and q holds its value.
- R10: A ce pulse while an access is in progress is ignored. The phase timing of the running access is unchanged and no write happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable, starts an access when idle |
| we | input | 1 | 1 = write, 0 = read, latched with ce |
| oe | input | 1 | Output enable of q |
| a | input | 6 | Word address |
| d | input | 4 | Write data |
| q | output | 4 | Read data, high impedance when oe is low |
| dec_on_o | output | 1 | Debug: decoders enabled |
| wl_on_o | output | 1 | Debug: word line on |
| sae_on_o | output | 1 | Debug: sense enable on |
| pch_on_o | output | 1 | Debug: bitline precharge on |

## Verification
The assertions take for granted that ce, we, a and d hold known values at every rising edge and that DUMMY_TICKS is at least 2, so that a sense window exists inside the word-line window. The stimulus changes all inputs only on falling edges and keeps them defined at all times. Random reads and writes are spaced at the access period. A directed ce pulse inside a running access checks that busy requests are ignored. Idle gaps with ce low check that the phase outputs stay quiet.

// File: rtl/sram_st_pkg.sv
package sram_st_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEC   = 2'd1,
    ST_WL    = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_e;
endpackage

// File: rtl/st_dummy_path.sv
module st_dummy_path #(
  parameter int TICKS   = 4,
  parameter bit REF_BIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wl_on,
  output logic cmpl
);
  localparam int CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sensed;

  always_comb begin
    cnt_d = wl_on ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the reference cell only develops its stored value after the full delay
  always_comb begin
    sensed = (wl_on && cnt_q == CNT_W'(TICKS - 1)) ? REF_BIT : ~REF_BIT;
    cmpl   = wl_on && (sensed == REF_BIT);
  end

  // R3: completion can only come while the word line is on
  p_cmpl_in_wl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |-> wl_on);
endmodule

// File: rtl/st_sequencer.sv
module st_sequencer
  import sram_st_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic we,
  input  logic cmpl,
  output logic cap_en,
  output logic dec_on,
  output logic wl_on,
  output logic sae_on,
  output logic pch_on,
  output logic wr_pulse,
  output logic rd_strobe
);
  seq_state_e state_q, state_d;
  logic       wr_q, wl_seen_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (ce)   state_d = ST_DEC;
      ST_DEC:             state_d = ST_WL;
      ST_WL:    if (cmpl) state_d = ST_RECOV;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      wl_seen_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wl_seen_q <= (state_q == ST_WL);
      if (cap_en) wr_q <= we;
    end
  end

  always_comb begin
    cap_en    = (state_q == ST_IDLE) && ce;
    dec_on    = (state_q == ST_DEC) || (state_q == ST_WL);
    wl_on     = (state_q == ST_WL);
    pch_on    = (state_q == ST_IDLE) || (state_q == ST_RECOV);
    sae_on    = wl_on && !wr_q && wl_seen_q;
    wr_pulse  = wl_on && wr_q && !wl_seen_q;
    rd_strobe = sae_on && cmpl;
  end

  // R4: sense lives inside a read word-line window
  p_sae_in_wl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sae_on |-> (wl_on && !wr_q));
  // R5: completion hands over to precharge with everything else off
  p_pch_after_cmpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> (pch_on && !wl_on && !dec_on && !sae_on));
  // R5: precharge and decode are never on together
  p_pch_dec_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pch_on |-> !dec_on);
  // R9: idle with ce low stays idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pch_on && !wl_on && !$past(wl_on) && !ce) |=> (pch_on && !dec_on));
endmodule

// File: rtl/st_array.sv
module st_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] a,
  input  logic [DATA_W-1:0] d,
  input  logic              wr_pulse,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= a;
      data_q <= d;
    end
    if (wr_pulse) mem[addr_q] <= data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_strobe) rdata_q <= mem[addr_q];
  end

  assign rdata = rdata_q;

  // R6: read data only moves on a sensed completion
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(rd_strobe));
endmodule

// File: rtl/selftimed_sram.sv
module selftimed_sram #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 4,
  parameter int DUMMY_TICKS = 4,
  parameter bit REF_BIT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] a,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              dec_on_o,
  output logic              wl_on_o,
  output logic              sae_on_o,
  output logic              pch_on_o
);
  localparam int LEN_W = $clog2(DUMMY_TICKS + 2);

  logic cap_en, dec_on, wl_on, sae_on, pch_on, wr_pulse, rd_strobe, cmpl;
  logic [DATA_W-1:0] rdata;

  st_sequencer u_seq (
    .clk, .rst_n, .ce, .we, .cmpl,
    .cap_en, .dec_on, .wl_on, .sae_on, .pch_on, .wr_pulse, .rd_strobe
  );

  st_dummy_path #(.TICKS(DUMMY_TICKS), .REF_BIT(REF_BIT)) u_dummy (
    .clk, .rst_n, .wl_on, .cmpl
  );

  st_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk, .rst_n, .cap_en, .a, .d, .wr_pulse, .rd_strobe, .rdata
  );

  assign q        = oe ? rdata : {DATA_W{1'bz}};
  assign dec_on_o = dec_on;
  assign wl_on_o  = wl_on;
  assign sae_on_o = sae_on;
  assign pch_on_o = pch_on;

  // word-line width check, counted rather than unrolled
  logic [LEN_W-1:0] wl_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wl_len_q <= '0;
    else if (wl_on) wl_len_q <= wl_len_q + LEN_W'(1);
    else            wl_len_q <= '0;
  end

  p_wl_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_on) |-> (wl_len_q == LEN_W'(DUMMY_TICKS)));
  p_wl_after_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_on) |-> $past(dec_on));
endmodule

// File: tb/tb_selftimed_sram.sv
module tb_selftimed_sram;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, we = 1'b0, oe = 1'b1;
  logic [5:0] a = '0;
  logic [3:0] d = '0;
  wire  [3:0] q;
  wire dec_on, wl_on, sae_on, pch_on;

  int n_chk = 0, n_bad = 0;
  logic [3:0] model [64];
  logic [3:0] last_q = 4'd0;

  always #10 clk = ~clk;

  selftimed_sram #(.DUMMY_TICKS(N)) dut (
    .clk, .rst_n, .ce, .we, .oe, .a, .d, .q,
    .dec_on_o(dec_on), .wl_on_o(wl_on), .sae_on_o(sae_on), .pch_on_o(pch_on)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] phases(input int k, input bit wr);
    logic [3:0] p; // {dec, wl, sae, pch}
    p[3] = (k >= 0 && k <= N);
    p[2] = (k >= 1 && k <= N);
    p[1] = !wr && (k >= 2 && k <= N);
    p[0] = (k == N + 1);
    return p;
  endfunction

  // one full access; poke adds a busy ce pulse in the word-line window
  task automatic access(input bit wr, input logic [5:0] ad, input logic [3:0] din, input bit poke);
    @(negedge clk);
    ce = 1'b1; we = wr; a = ad; d = din;
    for (int k = 0; k <= N + 1; k++) begin
      @(negedge clk);
      if (k == 1 && poke) begin
        ce = 1'b1; we = 1'b1; a = ad ^ 6'h3f; d = ~din;
      end else begin
        ce = 1'b0; we = 1'b0; a = $urandom; d = $urandom;
      end
      chk({dec_on, wl_on, sae_on, pch_on} === phases(k, wr),
          poke ? "R10 phases under busy ce" : (k <= 1 ? "R2/R3 phases" : "R3/R4/R5 phases"),
          {dec_on, wl_on, sae_on, pch_on}, phases(k, wr));
      if (!wr && oe) begin
        if (k <= N) chk(q === last_q, "R6 q holds before completion", q, last_q);
        else        chk(q === model[ad], "R6/R7 read data", q, model[ad]);
      end
    end
    if (wr) model[ad] = din;
    else    last_q = model[ad];
    @(negedge clk);
    ce = 1'b0;
    chk({dec_on, wl_on, sae_on, pch_on} === 4'b0001, "R5 idle after completion",
        {dec_on, wl_on, sae_on, pch_on}, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({dec_on, wl_on, sae_on, pch_on} === 4'b0001, "R1 reset phases", {dec_on, wl_on, sae_on, pch_on}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q === 4'd0, "R1 reset q", q, 0);

    for (int i = 0; i < 64; i++) access(1'b1, 6'(i), 4'($urandom), 1'b0);
    access(1'b0, 6'd5, 4'd0, 1'b0);
    access(1'b1, 6'd0, 4'hA, 1'b0);
    access(1'b1, 6'd63, 4'h5, 1'b0);
    access(1'b0, 6'd0, 4'd0, 1'b0);   // R7 boundary addresses
    access(1'b0, 6'd63, 4'd0, 1'b0);

    // R10: busy write poke to the complemented address must not land
    access(1'b0, 6'd12, 4'h3, 1'b1);
    access(1'b0, 6'd12 ^ 6'h3f, 4'd0, 1'b0);

    // R9: idle with ce low, random other inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      we = $urandom; a = $urandom; d = $urandom;
      chk({dec_on, wl_on, sae_on, pch_on} === 4'b0001, "R9 idle phases", {dec_on, wl_on, sae_on, pch_on}, 1);
      chk(q === last_q, "R9 q holds", q, last_q);
    end
    access(1'b0, 6'd0, 4'd0, 1'b0);   // R9 memory unchanged

    // R8: output enable
    @(negedge clk); oe = 1'b0;
    #1 chk(q === 4'bzzzz, "R8 high impedance", q, 0);
    access(1'b0, 6'd63, 4'd0, 1'b0);
    #1 chk(q === 4'bzzzz, "R8 high impedance after read", q, 0);
    oe = 1'b1;
    #1 chk(q === model[63], "R8 data after oe", q, model[63]);

    // random mix
    for (int i = 0; i < 120; i++) begin
      access(1'($urandom), 6'($urandom), 4'($urandom), 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule